// File: doc/BRIEF.md
# Three-Lane Mode-Selectable Serializer

This block turns a 21-bit parallel word into three serial data lanes and a fourth lane that carries a forwarded clock. It runs on a bit-rate clock. A one-cycle word strobe marks each word boundary, and at that strobe the block captures the whole word and the format select. The following bit times shift that word out.

Two formats are available. In the plain format each data lane sends its 7 raw bits per word. In the balanced format each lane sends 9 bits: its 7 bits, inverted or not, followed by a complementary pair of flag bits that tell the receiver whether it must invert them back. Each lane has its own encoder, which keeps the count of ones and zeros on the line close together so that the link can be AC-coupled. The clock lane sends 4 high and 3 low bit times per plain word. In balanced words it alternates between 5-high/4-low and 4-high/5-low, so its own ones and zeros also cancel.

The environment raises the strobe once every 9 bit-clock cycles for a balanced word and once every 7 for a plain word. It may leave idle gaps longer than that. The format pin is meant to be pulled up at the pad, so that an undriven pin selects balanced operation.

Top module: `trilane_ser`

## Requirements
- R1: After reset, and before the first word strobe, all three data lanes and the clock lane drive 0.
- R2: Lane k carries input bits 7k to 7k+6, lowest index first. The first bit appears in the bit-clock cycle right after the cycle in which the strobe is high.
- R3: A plain word (format select 0 at the strobe) puts exactly its 7 raw bits on each lane, with no inversion.
- R4: A balanced word (format select 1 at the strobe) puts 9 bits on each lane: 7 payload bits, then flag A, then flag B. B is always the complement of A. A=1 means the payload bits are the inverse of the input bits.
- R5: Each lane keeps a running disparity, which counts +1 for every one and -1 for every zero sent in balanced words. Reset clears it, and so does every plain word. A balanced word is inverted exactly when the running disparity is nonzero and has the same sign as the word's own disparity (2×ones−7).
- R6: Over a run of balanced words started from a cleared disparity, the running sum of ones minus zeros on each data lane never exceeds 10 in magnitude.
- R7: During a plain word the clock lane sends 1,1,1,1,0,0,0.
- R8: During balanced words the clock lane alternates between 5 high then 4 low and 4 high then 5 low. The 5-high shape comes first after reset and after any plain word. Its running sum from that point stays between 0 and 5.
- R9: Changes on the data inputs and the format select between strobes do not alter the word being sent.
- R10: The format takes effect only at a strobe, so back-to-back words in different formats each keep their own length and encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_stb_i | input | 1 | High for one cycle at each word boundary; captures data and format |
| balanced_i | input | 1 | Format select: 1 balanced (9 bits per lane), 0 plain (7 bits per lane) |
| data_i | input | 21 | Parallel input word |
| lane_o | output | 3 | Serial data lanes, bit k is lane k |
| fwdclk_o | output | 1 | Forwarded parallel-rate clock lane |

## Verification
The hardest case to reach is an encoder at the edge of its range, with a running disparity of +7 or -7, where the inversion choice decides whether the line bound holds. A nonzero disparity that a plain word then has to wipe out is just as hard to reach. The stimulus reaches both with runs of all-ones and all-zeros balanced words, which push each lane to its extreme. It then switches formats mid-stream, both back to back and with idle gaps. A reference deserializer in the bench rebuilds every word. It tracks its own disparity and clock phase, so that a wrong inversion flag or a wrong clock shape after a format change shows up in the cycle where it occurs.

// File: rtl/trilane_pkg.sv
package trilane_pkg;
  typedef enum logic {
    FMT_PLAIN = 1'b0,
    FMT_BAL   = 1'b1
  } fmt_e;

  localparam int BAL_BITS = 2;
endpackage

// File: rtl/trilane_lane.sv
module trilane_lane
  import trilane_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  fmt_e         fmt_i,
  input  logic [W-1:0] data_i,
  output logic         ser_o
);
  localparam int SYM_W = W + BAL_BITS;
  localparam int DW    = $clog2(W + 1) + 2;
  localparam logic signed [DW-1:0] W_S = DW'(W);

  logic signed [DW-1:0] disp_q, disp_d, wdisp;
  logic [DW-1:0]        ones;
  logic                 inv, d_pos, w_pos;
  logic [W-1:0]         payload;
  logic [SYM_W-1:0]     sym, shreg_q, shreg_d;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + DW'(data_i[i]);
    wdisp   = $signed(ones << 1) - W_S;
    d_pos   = ~disp_q[DW-1];
    w_pos   = ~wdisp[DW-1] && (wdisp != '0);
    inv     = (fmt_i == FMT_BAL) && (disp_q != '0) && (d_pos == w_pos);
    payload = inv ? ~data_i : data_i;
    if (fmt_i == FMT_BAL) sym = {~inv, inv, payload};
    else                  sym = {{BAL_BITS{1'b0}}, payload};
  end

  always_comb begin
    shreg_d = {1'b0, shreg_q[SYM_W-1:1]};
    disp_d  = disp_q;
    if (load_i) begin
      shreg_d = sym;
      if (fmt_i == FMT_BAL) disp_d = inv ? (disp_q - wdisp) : (disp_q + wdisp);
      else                  disp_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      disp_q  <= '0;
    end else begin
      shreg_q <= shreg_d;
      disp_q  <= disp_d;
    end
  end

  assign ser_o = shreg_q[0];
endmodule

// File: rtl/trilane_fclk.sv
module trilane_fclk
  import trilane_pkg::*;
#(
  parameter int W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  fmt_e fmt_i,
  output logic ser_o
);
  localparam int SYM_W   = W + BAL_BITS;
  localparam int H_PLAIN = (W + 1) / 2;
  localparam int H_LONG  = (SYM_W + 1) / 2;
  localparam int H_SHORT = SYM_W / 2;

  function automatic logic [SYM_W-1:0] head_ones(input int h);
    logic [SYM_W-1:0] m;
    m = '0;
    for (int i = 0; i < SYM_W; i++) if (i < h) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [SYM_W-1:0] PAT_PLAIN = head_ones(H_PLAIN);
  localparam logic [SYM_W-1:0] PAT_LONG  = head_ones(H_LONG);
  localparam logic [SYM_W-1:0] PAT_SHORT = head_ones(H_SHORT);

  logic [SYM_W-1:0] shreg_q, shreg_d;
  logic             ph_q, ph_d;

  always_comb begin
    shreg_d = {1'b0, shreg_q[SYM_W-1:1]};
    ph_d    = ph_q;
    if (load_i) begin
      if (fmt_i == FMT_BAL) begin
        shreg_d = ph_q ? PAT_SHORT : PAT_LONG;
        ph_d    = ~ph_q;
      end else begin
        shreg_d = PAT_PLAIN;
        ph_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      ph_q    <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      ph_q    <= ph_d;
    end
  end

  assign ser_o = shreg_q[0];
endmodule

// File: rtl/trilane_ser.sv
module trilane_ser
  import trilane_pkg::*;
#(
  parameter int LANE_CNT = 3,
  parameter int LANE_W   = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       word_stb_i,
  input  logic                       balanced_i,
  input  logic [LANE_CNT*LANE_W-1:0] data_i,
  output logic [LANE_CNT-1:0]        lane_o,
  output logic                       fwdclk_o
);
  logic rst_meta_q, rst_q;
  fmt_e fmt_in, mode_q, mode_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  assign fmt_in = balanced_i ? FMT_BAL : FMT_PLAIN;

  always_comb begin
    mode_d = mode_q;
    if (word_stb_i) mode_d = fmt_in;
  end

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) mode_q <= FMT_BAL;
    else        mode_q <= mode_d;
  end

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    trilane_lane #(.W(LANE_W)) lane_i (
      .clk_i  (clk_i),
      .rst_ni (rst_q),
      .load_i (word_stb_i),
      .fmt_i  (mode_d),
      .data_i (data_i[g*LANE_W +: LANE_W]),
      .ser_o  (lane_o[g])
    );
  end

  trilane_fclk #(.W(LANE_W)) fclk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .load_i (word_stb_i),
    .fmt_i  (mode_d),
    .ser_o  (fwdclk_o)
  );
endmodule

// File: rtl/trilane_ser_chk.sv
module trilane_ser_chk #(
  parameter int LANE_CNT = 3,
  parameter int LANE_W   = 7
) (
  input logic                       clk_i,
  input logic                       rst_n,
  input logic                       word_stb_i,
  input logic                       balanced_i,
  input logic [LANE_CNT*LANE_W-1:0] data_i,
  input logic [LANE_CNT-1:0]        lane_o,
  input logic                       fwdclk_o,
  input logic                       bal_q
);
  localparam int SYM_W = LANE_W + 2;
  localparam int CW    = $clog2(SYM_W + 1);
  localparam logic signed [7:0] DSV_S = 8'(LANE_W + 3);
  localparam logic signed [7:0] CLK_S = 8'((SYM_W + 1) / 2);

  logic          started_q;
  logic [CW-1:0] cnt_q;
  logic          acc;
  logic signed [7:0] csum_q;

  assign acc = started_q && bal_q && (cnt_q < CW'(SYM_W));

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      cnt_q     <= CW'(SYM_W);
      csum_q    <= '0;
    end else begin
      started_q <= started_q | word_stb_i;
      if (word_stb_i) cnt_q <= '0;
      else if (cnt_q < CW'(SYM_W)) cnt_q <= cnt_q + 1'b1;
      if (!started_q || !bal_q) csum_q <= '0;
      else if (acc) csum_q <= csum_q + (fwdclk_o ? 8'sd1 : -8'sd1);
    end
  end

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_sum
    logic signed [7:0] sum_q;
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else if (!started_q || !bal_q) sum_q <= '0;
      else if (acc) sum_q <= sum_q + (lane_o[g] ? 8'sd1 : -8'sd1);
    end

    AST_LANE_DSV: assert property (@(posedge clk_i) disable iff (!rst_n)
      (sum_q <= DSV_S) && (sum_q >= -DSV_S)); // R6

    AST_PLAIN_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_n)
      (word_stb_i && !balanced_i) |=> (lane_o[g] == $past(data_i[g*LANE_W]))); // R2
  end

  AST_CLK_DSV: assert property (@(posedge clk_i) disable iff (!rst_n)
    (csum_q >= 8'sd0) && (csum_q <= CLK_S)); // R8

  AST_CLK_START: assert property (@(posedge clk_i) disable iff (!rst_n)
    word_stb_i |=> fwdclk_o); // R7

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !word_stb_i |=> $stable(bal_q)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    !started_q |-> (lane_o == '0) && !fwdclk_o); // R1
endmodule

bind trilane_ser trilane_ser_chk #(.LANE_CNT(LANE_CNT), .LANE_W(LANE_W)) chk_i (
  .clk_i      (clk_i),
  .rst_n      (rst_q),
  .word_stb_i (word_stb_i),
  .balanced_i (balanced_i),
  .data_i     (data_i),
  .lane_o     (lane_o),
  .fwdclk_o   (fwdclk_o),
  .bal_q      (mode_q == trilane_pkg::FMT_BAL)
);

// File: tb/trilane_ser_tb_top.sv
module trilane_ser_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_stb = 1'b0;
  logic        balanced = 1'b1;
  logic [20:0] data = '0;
  logic [2:0]  lane_o;
  logic        fwdclk_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  trilane_ser dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .word_stb_i (word_stb),
    .balanced_i (balanced),
    .data_i     (data),
    .lane_o     (lane_o),
    .fwdclk_o   (fwdclk_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard queue: {balanced, data}
  logic [21:0] exp_q[$];

  task automatic send_word(input logic [20:0] d, input bit b, input int gap);
    data     = d;
    balanced = b;
    word_stb = 1'b1;
    exp_q.push_back({b, d});
    @(posedge clk); #1;
    word_stb = 1'b0;
    data     = ~d;   // R9: disturb inputs mid-word
    balanced = ~b;
    repeat ((b ? 9 : 7) - 1 + gap) @(posedge clk);
    #1;
  endtask

  // reference deserializer state
  logic [21:0] cur;
  logic [8:0]  lb [3];
  logic [8:0]  cb;
  int          cnt = 0;
  int          nbits = 0;
  bit          coll = 1'b0;
  int          m_disp [3] = '{0, 0, 0};
  int          m_sum  [3] = '{0, 0, 0};
  int          c_sum = 0;
  bit          m_ph = 1'b0;

  task automatic check_word();
    bit b;
    b = cur[21];
    for (int l = 0; l < 3; l++) begin
      logic [6:0] dexp, got;
      int w, mx;
      bit inv;
      dexp = cur[l*7 +: 7];
      w    = 2 * $countones(dexp) - 7;
      inv  = b && (m_disp[l] != 0) && ((m_disp[l] > 0) == (w > 0));
      got  = lb[l][6:0];
      if (b) begin
        chk(lb[l][8] == ~lb[l][7], "R4", "flag pair complement", lb[l][8:7], {~lb[l][7], lb[l][7]});
        chk(lb[l][7] == inv, "R5", "inversion flag", lb[l][7], inv);
        if (lb[l][7]) got = ~got;
        m_disp[l] += inv ? -w : w;
        mx = 0;
        for (int i = 0; i < 9; i++) begin
          m_sum[l] += lb[l][i] ? 1 : -1;
          if (m_sum[l] > mx) mx = m_sum[l];
          if (-m_sum[l] > mx) mx = -m_sum[l];
        end
        chk(mx <= 10, "R6", "lane running sum magnitude", mx, 10);
        chk(got == dexp, "R4 R2 R9 R10", "balanced lane data", got, dexp);
      end else begin
        m_disp[l] = 0;
        m_sum[l]  = 0;
        chk(got == dexp, "R3 R2 R9 R10", "plain lane data", got, dexp);
      end
    end
    begin
      int h, cmin, cmax;
      logic [8:0] ce, msk;
      if (b) begin h = m_ph ? 4 : 5; m_ph = ~m_ph; msk = 9'h1FF; end
      else   begin h = 4; m_ph = 1'b0; msk = 9'h07F; c_sum = 0; end
      ce = '0;
      for (int i = 0; i < 9; i++) if (i < h) ce[i] = 1'b1;
      chk((cb & msk) == ce, b ? "R8" : "R7", "clock lane shape", cb & msk, ce);
      if (b) begin
        cmin = c_sum; cmax = c_sum;
        for (int i = 0; i < 9; i++) begin
          c_sum += cb[i] ? 1 : -1;
          if (c_sum < cmin) cmin = c_sum;
          if (c_sum > cmax) cmax = c_sum;
        end
        chk(cmin >= 0 && cmax <= 5, "R8", "clock lane sum range", {cmin[15:0], cmax[15:0]}, 5);
      end
    end
  endtask

  always @(negedge clk) begin
    if (coll) begin
      for (int l = 0; l < 3; l++) lb[l][cnt] = lane_o[l];
      cb[cnt] = fwdclk_o;
      cnt++;
      if (cnt == nbits) begin
        check_word();
        coll = 1'b0;
      end
    end
    if (rst_ni && word_stb) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "strobe without expected word", 0, 1);
      end else begin
        cur   = exp_q.pop_front();
        nbits = cur[21] ? 9 : 7;
        cnt   = 0;
        coll  = 1'b1;
        lb[0] = '0; lb[1] = '0; lb[2] = '0; cb = '0;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lane_o == 3'b000 && fwdclk_o == 1'b0, "R1", "outputs in reset", {lane_o, fwdclk_o}, 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(lane_o == 3'b000 && fwdclk_o == 1'b0, "R1", "outputs after reset", {lane_o, fwdclk_o}, 0);
    @(posedge clk); #1;

    // balanced extremes push disparity to its edges
    send_word(21'h1FFFFF, 1'b1, 0);
    send_word(21'h1FFFFF, 1'b1, 0);
    send_word(21'h000000, 1'b1, 0);
    send_word(21'h000000, 1'b1, 0);
    send_word(21'h000000, 1'b1, 0);
    send_word(21'h0FE07F, 1'b1, 0);
    for (int i = 0; i < 24; i++) send_word(21'($urandom), 1'b1, 0);
    // plain words, back to back
    send_word(21'h000000, 1'b0, 0);
    send_word(21'h1FFFFF, 1'b0, 0);
    send_word(21'h155555, 1'b0, 0);
    for (int i = 0; i < 8; i++) send_word(21'($urandom), 1'b0, 0);
    // idle gap, then balanced again with cleared state
    send_word(21'h1FFFFF, 1'b1, 5);
    send_word(21'h1FFFFF, 1'b1, 0);
    send_word(21'h1FFFFF, 1'b1, 0);
    // alternating formats, with and without gaps
    for (int i = 0; i < 12; i++) send_word(21'($urandom), i[0], (i % 3 == 2) ? 3 : 0);
    for (int i = 0; i < 10; i++) send_word(21'($urandom), 1'b1, 0);

    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0 && !coll, "R10", "all words delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule